// File: doc/BRIEF.md
# Walking-One Link Self-Test Generator and Checker

This block holds the two ends of a link self-test. On the sending side, a generator normally passes user words through to the link port. While test mode is requested, it replaces them with a repeating walking-one pattern. Each pattern cycle starts with a control-marked word that carries zero data. It then sends one word per data bit, each with a single bit set, starting at bit 0. The cycle is therefore one word longer than the selected data width (8, 16 or 32 bits at the default width). Only whole cycles are sent. If test mode is dropped part way through a cycle, the generator completes that cycle before it hands the port back to user data.

On the receiving side, a checker watches the incoming words. On entering test mode it waits for a control-marked word and aligns on it. From there it compares every word with the expected pattern, reports mismatches on a per-word error output and on a sticky error indicator, and shows a test-active indicator. Each end uses a simple word-valid handshake in place of a physical link. The generator can be throttled by the link side with a ready input.

The generator FSM has three states. GEN_NORMAL passes user data and moves to GEN_PATTERN when test mode is requested. GEN_PATTERN sends pattern words. It returns to GEN_NORMAL on release when no word of the current cycle is pending, and moves to GEN_FINISH on release in the middle of a cycle. GEN_FINISH sends the rest of the cycle. It returns to GEN_NORMAL after the last word, or to GEN_PATTERN if test mode is requested again.

The checker FSM has four states. CHK_OFF passes words through and moves to CHK_HUNT on a test request. CHK_HUNT moves to CHK_LOCK on a control word, or to CHK_OFF on release. CHK_LOCK moves to CHK_OFF on release at a cycle boundary, or to CHK_TAIL on release in the middle of a cycle. CHK_TAIL moves to CHK_OFF at the end of the cycle, or back to CHK_LOCK if test mode is requested again.

Top module: `walk_link_selftest`

## Requirements
- R1: In a pattern cycle, word 0 has the control flag at 1 and all data bits at 0. Word k, for k from 1 to W, has the control flag at 0 and only data bit k-1 set. W is latched at test entry from `wsel`: 00 gives DW/4, 01 gives DW/2, and 10 or 11 give DW.
- R2: A pattern cycle is W+1 words long, and cycles repeat back to back. Word 0 is the first word offered in the cycle after `test_en` is first sampled high.
- R3: While `lnk_ready` is low, the offered pattern word is held and the pattern does not advance. `usr_ready` stays low throughout test mode.
- R4: When `test_en` falls in the middle of a cycle, the generator sends the remaining words of that cycle and then returns to pass-through. When `test_en` falls at a cycle boundary, no word of a new cycle is offered: `lnk_valid` is 0 in that cycle, and pass-through follows.
- R5: Outside test mode, `lnk_word`, `lnk_ctrl` and `lnk_valid` follow the user inputs, and `usr_ready` equals `lnk_ready`.
- R6: `rst_n` low, asynchronous and taking priority over `test_en`, forces pass-through, clears both pattern positions to word 0, and holds both indicators and `err_out` at 0.
- R7: After test entry, received words before the first control-marked word are neither compared nor delivered. Comparison and delivery start with that control word.
- R8: A mismatch in data or in the control flag raises `err_out` in the same cycle. This includes a control-marked word that arrives before its cycle is complete. `ind_err` is 1 from the next cycle until test mode ends.
- R9: During test, a received test word is delivered on `dst_valid` only while `tdo_n` is 0. Outside test, received words pass straight through.
- R10: `ind_test` is 1 while the checker is in test mode, from the cycle after `test_en` is sampled high. Both `ind_test` and `ind_err` drop in the same cycle that `test_en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_en | input | 1 | Test mode request |
| wsel | input | 2 | Width select: 00 DW/4, 01 DW/2, 1x DW |
| usr_word | input | DW | User data to send |
| usr_ctrl | input | 1 | User control flag |
| usr_valid | input | 1 | User word valid |
| usr_ready | output | 1 | Generator accepts user word |
| lnk_word | output | DW | Word offered to the link |
| lnk_ctrl | output | 1 | Control flag offered to the link |
| lnk_valid | output | 1 | Link word valid |
| lnk_ready | input | 1 | Link accepts word (throttle) |
| rx_word | input | DW | Received word |
| rx_ctrl | input | 1 | Received control flag |
| rx_valid | input | 1 | Received word valid |
| tdo_n | input | 1 | Deliver test words when 0 |
| dst_word | output | DW | Word delivered to the user |
| dst_ctrl | output | 1 | Delivered control flag |
| dst_valid | output | 1 | Delivered word valid |
| err_out | output | 1 | Per-word compare error |
| ind_test | output | 1 | Test-active indicator |
| ind_err | output | 1 | Sticky data-error indicator |

## Verification
The bench builds the block with DW=32 and sweeps `wsel` through all four codes, so the 9-, 17- and 33-word cycles, and the alias of code 11 to the full width, are each run end to end. Throttle gaps of different spacing, and delivery both on and off, come from the vector table. Directed cases cover the following: release in the middle of a cycle and at a boundary; bit and control-flag corruption injected on the receive path; hiding the first control word so that the checker has to hunt a full cycle; and reset asserted while a pattern is running.

// File: rtl/walk_link_pkg.sv
package walk_link_pkg;

    typedef enum logic [1:0] {
        GEN_NORMAL,
        GEN_PATTERN,
        GEN_FINISH
    } gen_state_t;

    typedef enum logic [1:0] {
        CHK_OFF,
        CHK_HUNT,
        CHK_LOCK,
        CHK_TAIL
    } chk_state_t;

    localparam logic [1:0] WSEL_QUARTER = 2'b00;
    localparam logic [1:0] WSEL_HALF    = 2'b01;

endpackage

// File: rtl/walk_pattern.sv
// Expected walking-one word for a given position in the cycle.
module walk_pattern
    import walk_link_pkg::*;
#(
    parameter int DW = 32,
    localparam int IW = $clog2(DW + 1)
) (
    input  logic [IW-1:0] idx,
    input  logic [1:0]    wsel,
    output logic [DW-1:0] data,
    output logic          ctrl,
    output logic          last
);
    localparam logic [IW-1:0] LAST_Q = IW'(DW / 4);
    localparam logic [IW-1:0] LAST_H = IW'(DW / 2);
    localparam logic [IW-1:0] LAST_F = IW'(DW);
    localparam logic [DW-1:0] ONE    = DW'(1);

    logic [IW-1:0] last_idx;

    always_comb begin
        unique case (wsel)
            WSEL_QUARTER: last_idx = LAST_Q;
            WSEL_HALF:    last_idx = LAST_H;
            default:      last_idx = LAST_F;
        endcase
    end

    always_comb begin
        ctrl = (idx == '0);
        data = ctrl ? '0 : (ONE << (idx - 1'b1));
        last = (idx == last_idx);
    end
endmodule

// File: rtl/walk_gen.sv
// Source side: user pass-through or walking-one pattern.
module walk_gen
    import walk_link_pkg::*;
#(
    parameter int DW = 32,
    localparam int IW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_en,
    input  logic [1:0]    wsel,
    input  logic [DW-1:0] usr_word,
    input  logic          usr_ctrl,
    input  logic          usr_valid,
    output logic          usr_ready,
    output logic [DW-1:0] lnk_word,
    output logic          lnk_ctrl,
    output logic          lnk_valid,
    input  logic          lnk_ready,
    output logic          pat_active
);
    gen_state_t    state_q, state_d;
    logic [IW-1:0] idx_q, idx_nxt;
    logic [1:0]    wsel_q;
    logic [DW-1:0] pat_data;
    logic          pat_ctrl, pat_last;
    logic          hold_off, hs;

    walk_pattern #(.DW(DW)) u_pat (
        .idx  (idx_q),
        .wsel (wsel_q),
        .data (pat_data),
        .ctrl (pat_ctrl),
        .last (pat_last)
    );

    // At a cycle boundary with test released, no new cycle is started.
    assign hold_off = (state_q == GEN_PATTERN) && (idx_q == '0) && !test_en;
    assign hs       = (state_q != GEN_NORMAL) && !hold_off && lnk_ready;
    assign idx_nxt  = hs ? (pat_last ? '0 : idx_q + 1'b1) : idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_NORMAL:  if (test_en) state_d = GEN_PATTERN;
            GEN_PATTERN: if (!test_en) state_d = (idx_nxt == '0) ? GEN_NORMAL : GEN_FINISH;
            GEN_FINISH: begin
                if (test_en)              state_d = GEN_PATTERN;
                else if (idx_nxt == '0)   state_d = GEN_NORMAL;
            end
            default:     state_d = GEN_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GEN_NORMAL;
            idx_q   <= '0;
            wsel_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= (state_d == GEN_NORMAL) ? '0 : idx_nxt;
            if (state_q == GEN_NORMAL) wsel_q <= wsel;
        end
    end

    always_comb begin
        pat_active = (state_q != GEN_NORMAL);
        unique case (state_q)
            GEN_NORMAL: begin
                lnk_word  = usr_word;
                lnk_ctrl  = usr_ctrl;
                lnk_valid = usr_valid;
                usr_ready = lnk_ready;
            end
            default: begin
                lnk_word  = pat_data;
                lnk_ctrl  = pat_ctrl;
                lnk_valid = !hold_off;
                usr_ready = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/walk_chk.sv
// Destination side: aligns on the control word and compares the pattern.
module walk_chk
    import walk_link_pkg::*;
#(
    parameter int DW = 32,
    localparam int IW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_en,
    input  logic [1:0]    wsel,
    input  logic [DW-1:0] rx_word,
    input  logic          rx_ctrl,
    input  logic          rx_valid,
    input  logic          tdo_n,
    output logic [DW-1:0] dst_word,
    output logic          dst_ctrl,
    output logic          dst_valid,
    output logic          err_out,
    output logic          ind_test,
    output logic          ind_err,
    output logic          synced
);
    chk_state_t    state_q, state_d;
    logic [IW-1:0] idx_q, idx_nxt;
    logic [1:0]    wsel_q;
    logic          err_q;
    logic [DW-1:0] exp_data;
    logic          exp_ctrl, exp_last;
    logic          take, mism;

    walk_pattern #(.DW(DW)) u_pat (
        .idx  (idx_q),
        .wsel (wsel_q),
        .data (exp_data),
        .ctrl (exp_ctrl),
        .last (exp_last)
    );

    always_comb begin
        unique case (state_q)
            CHK_LOCK, CHK_TAIL: take = rx_valid;
            CHK_HUNT:           take = rx_valid && rx_ctrl;
            default:            take = 1'b0;
        endcase
    end

    assign mism    = (rx_word != exp_data) || (rx_ctrl != exp_ctrl);
    assign idx_nxt = take ? (exp_last ? '0 : idx_q + 1'b1) : idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CHK_OFF:  if (test_en) state_d = CHK_HUNT;
            CHK_HUNT: begin
                if (!test_en)  state_d = CHK_OFF;
                else if (take) state_d = CHK_LOCK;
            end
            CHK_LOCK: if (!test_en) state_d = (idx_nxt == '0) ? CHK_OFF : CHK_TAIL;
            CHK_TAIL: begin
                if (test_en)            state_d = CHK_LOCK;
                else if (idx_nxt == '0) state_d = CHK_OFF;
            end
            default:  state_d = CHK_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CHK_OFF;
            idx_q   <= '0;
            wsel_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= (state_d == CHK_OFF) ? '0 : idx_nxt;
            if (state_q == CHK_OFF) wsel_q <= wsel;
            if (!test_en || state_q == CHK_OFF) err_q <= 1'b0;
            else if (err_out)                   err_q <= 1'b1;
        end
    end

    always_comb begin
        dst_word = rx_word;
        dst_ctrl = rx_ctrl;
        synced   = (state_q == CHK_LOCK) || (state_q == CHK_TAIL);
        unique case (state_q)
            CHK_OFF: begin
                dst_valid = rx_valid;
                err_out   = 1'b0;
            end
            default: begin
                dst_valid = take && !tdo_n;
                err_out   = take && mism && test_en;
            end
        endcase
        ind_test = test_en && (state_q != CHK_OFF);
        ind_err  = test_en && err_q;
    end
endmodule

// File: rtl/walk_link_selftest.sv
module walk_link_selftest #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_en,
    input  logic [1:0]    wsel,
    input  logic [DW-1:0] usr_word,
    input  logic          usr_ctrl,
    input  logic          usr_valid,
    output logic          usr_ready,
    output logic [DW-1:0] lnk_word,
    output logic          lnk_ctrl,
    output logic          lnk_valid,
    input  logic          lnk_ready,
    input  logic [DW-1:0] rx_word,
    input  logic          rx_ctrl,
    input  logic          rx_valid,
    input  logic          tdo_n,
    output logic [DW-1:0] dst_word,
    output logic          dst_ctrl,
    output logic          dst_valid,
    output logic          err_out,
    output logic          ind_test,
    output logic          ind_err
);
    logic gen_pat;
    logic chk_sync;

    walk_gen #(.DW(DW)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_en    (test_en),
        .wsel       (wsel),
        .usr_word   (usr_word),
        .usr_ctrl   (usr_ctrl),
        .usr_valid  (usr_valid),
        .usr_ready  (usr_ready),
        .lnk_word   (lnk_word),
        .lnk_ctrl   (lnk_ctrl),
        .lnk_valid  (lnk_valid),
        .lnk_ready  (lnk_ready),
        .pat_active (gen_pat)
    );

    walk_chk #(.DW(DW)) u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_en   (test_en),
        .wsel      (wsel),
        .rx_word   (rx_word),
        .rx_ctrl   (rx_ctrl),
        .rx_valid  (rx_valid),
        .tdo_n     (tdo_n),
        .dst_word  (dst_word),
        .dst_ctrl  (dst_ctrl),
        .dst_valid (dst_valid),
        .err_out   (err_out),
        .ind_test  (ind_test),
        .ind_err   (ind_err),
        .synced    (chk_sync)
    );
endmodule

// File: rtl/walk_link_selftest_sva.sv
module walk_link_selftest_sva #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] lnk_word,
    input logic          lnk_ctrl,
    input logic          lnk_valid,
    input logic          lnk_ready,
    input logic          rx_ctrl,
    input logic          rx_valid,
    input logic          err_out,
    input logic          ind_err,
    input logic          gen_pat,
    input logic          chk_sync
);
    // R1
    walk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_pat && lnk_valid && !lnk_ctrl) |-> ($countones(lnk_word) == 1));

    // R1
    ctrl_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_pat && lnk_valid && lnk_ctrl) |-> (lnk_word == '0));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_pat && !lnk_ready) |=> (!gen_pat || ($stable(lnk_word) && $stable(lnk_ctrl))));

    // R7
    align_on_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chk_sync) |-> $past(rx_valid && rx_ctrl));

    // R8
    err_ind_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ind_err) |-> $past(err_out));
endmodule

bind walk_link_selftest walk_link_selftest_sva #(.DW(DW)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .lnk_word  (lnk_word),
    .lnk_ctrl  (lnk_ctrl),
    .lnk_valid (lnk_valid),
    .lnk_ready (lnk_ready),
    .rx_ctrl   (rx_ctrl),
    .rx_valid  (rx_valid),
    .err_out   (err_out),
    .ind_err   (ind_err),
    .gen_pat   (gen_pat),
    .chk_sync  (chk_sync)
);

// File: tb/tb_walk_link_selftest.sv
module tb_walk_link_selftest;
    localparam int DW = 32;

    typedef struct packed {
        logic [1:0] ws;
        logic [2:0] stall;
        logic       tdo;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{2'd0, 3'd0, 1'b0},
        '{2'd1, 3'd3, 1'b0},
        '{2'd2, 3'd2, 1'b1},
        '{2'd3, 3'd0, 1'b0}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, test_en, usr_ctrl, usr_valid, usr_ready;
    logic [1:0]    wsel;
    logic [DW-1:0] usr_word, lnk_word, rx_word, dst_word, inj_word;
    logic          lnk_ctrl, lnk_valid, lnk_ready, rx_ctrl, rx_valid, tdo_n;
    logic          dst_ctrl, dst_valid, err_out, ind_test, ind_err, inj_ctrl, hide;

    assign rx_word  = lnk_word ^ inj_word;
    assign rx_ctrl  = lnk_ctrl ^ inj_ctrl;
    assign rx_valid = lnk_valid & lnk_ready & ~hide;

    walk_link_selftest #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .wsel(wsel),
        .usr_word(usr_word), .usr_ctrl(usr_ctrl), .usr_valid(usr_valid), .usr_ready(usr_ready),
        .lnk_word(lnk_word), .lnk_ctrl(lnk_ctrl), .lnk_valid(lnk_valid), .lnk_ready(lnk_ready),
        .rx_word(rx_word), .rx_ctrl(rx_ctrl), .rx_valid(rx_valid), .tdo_n(tdo_n),
        .dst_word(dst_word), .dst_ctrl(dst_ctrl), .dst_valid(dst_valid),
        .err_out(err_out), .ind_test(ind_test), .ind_err(ind_err)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    int  k = 0;
    int  wlen = 8;
    bit  done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] expw(input int pos);
        return (pos == 0) ? '0 : (DW'(1) << (pos - 1));
    endfunction

    function automatic int width_of(input logic [1:0] s);
        return (s == 2'd0) ? DW / 4 : (s == 2'd1) ? DW / 2 : DW;
    endfunction

    task automatic adv();
        k = (k == wlen) ? 0 : k + 1;
    endtask

    task automatic check_word(input string req);
        chk(lnk_valid && lnk_word == expw(k) && lnk_ctrl == (k == 0), req,
            {31'd0, lnk_ctrl, lnk_word}, {31'd0, (k == 0), expw(k)});
    endtask

    // Runs n accepted pattern words, optionally with throttle gaps.
    task automatic run_words(input int n, input int stall, input string req);
        int sent = 0;
        int cyc = 0;
        while (sent < n) begin
            @(negedge clk);
            lnk_ready = !(stall != 0 && (cyc % stall) == stall - 1);
            cyc++;
            #1;
            chk(!usr_ready, "R3", usr_ready, 0);
            if (lnk_ready) begin
                check_word(req);
                chk(!err_out, "R8", err_out, 0);
                chk(dst_valid == !tdo_n, "R9", dst_valid, !tdo_n);
                chk(ind_test, "R10", ind_test, 1);
                adv();
                sent++;
            end else begin
                chk(lnk_word == expw(k) && !dst_valid, "R3", lnk_word, expw(k));
            end
        end
    endtask

    task automatic release_at_boundary();
        @(negedge clk);
        test_en = 1'b0; lnk_ready = 1'b1; inj_word = '0; inj_ctrl = 1'b0; hide = 1'b0;
        #1;
        chk(!lnk_valid, "R4", lnk_valid, 0);
        chk(!ind_test && !ind_err, "R10", {ind_test, ind_err}, 0);
        @(negedge clk); #1;
        chk(lnk_word == usr_word && lnk_valid && usr_ready, "R5", lnk_word, usr_word);
        chk(dst_word == rx_word && dst_valid == rx_valid, "R9", dst_word, rx_word);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin : main
        rst_n = 1'b0; test_en = 1'b1; wsel = 2'd0; tdo_n = 1'b0;
        usr_word = 32'h5A3C_96E1; usr_ctrl = 1'b0; usr_valid = 1'b1;
        lnk_ready = 1'b1; inj_word = '0; inj_ctrl = 1'b0; hide = 1'b0;

        // R6: reset wins over a test request
        repeat (3) @(negedge clk);
        #1;
        chk(lnk_word == usr_word && lnk_valid && usr_ready, "R6", lnk_word, usr_word);
        chk(!ind_test && !ind_err && !err_out, "R6", {ind_test, ind_err, err_out}, 0);
        test_en = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk(lnk_word == usr_word && usr_ready, "R5", lnk_word, usr_word);

        // Vector table: all width codes, throttle spacing, delivery on/off (R1 R2 R3 R9)
        foreach (VEC[i]) begin
            @(negedge clk);
            wsel = VEC[i].ws; tdo_n = VEC[i].tdo; test_en = 1'b1;
            k = 0; wlen = width_of(VEC[i].ws);
            run_words(2 * (wlen + 1), int'(VEC[i].stall), "R1");
            chk(k == 0, "R2", k, 0);
            release_at_boundary();
        end

        // R4: release in the middle of a cycle
        @(negedge clk);
        wsel = 2'd0; tdo_n = 1'b0; test_en = 1'b1; k = 0; wlen = 8;
        run_words(4, 0, "R2");
        @(negedge clk);
        test_en = 1'b0; #1;
        chk(!ind_test && !ind_err, "R10", {ind_test, ind_err}, 0);
        check_word("R4");
        adv();
        while (k != 0) begin
            @(negedge clk); #1;
            check_word("R4");
            chk(!err_out && !ind_test, "R4", {err_out, ind_test}, 0);
            adv();
        end
        @(negedge clk); #1;
        chk(lnk_word == usr_word && lnk_valid && usr_ready, "R4", lnk_word, usr_word);

        // R8: corrupted data bit and early control word
        @(negedge clk);
        wsel = 2'd1; test_en = 1'b1; k = 0; wlen = 16;
        for (int i = 0; i < 34; i++) begin
            @(negedge clk);
            inj_word = (i == 3) ? 32'h0000_0080 : '0;
            inj_ctrl = (i == 6);
            #1;
            check_word("R1");
            chk(err_out == (i == 3 || i == 6), "R8", err_out, (i == 3 || i == 6));
            if (i == 4) chk(ind_err, "R8", ind_err, 1);
            adv();
        end
        release_at_boundary();

        // R7: first control word hidden, checker hunts a full cycle
        @(negedge clk);
        wsel = 2'd0; test_en = 1'b1; k = 0; wlen = 8;
        for (int i = 0; i < 18; i++) begin
            @(negedge clk);
            hide = (i == 0);
            inj_word = (i == 2) ? 32'h0000_0020 : '0;
            #1;
            chk(!err_out, "R7", err_out, 0);
            chk(dst_valid == (i > 8), "R7", dst_valid, (i > 8));
            adv();
        end
        release_at_boundary();

        // R6: reset while a pattern runs, then restart from word 0
        @(negedge clk);
        wsel = 2'd2; test_en = 1'b1; k = 0; wlen = 32;
        run_words(3, 0, "R1");
        @(negedge clk);
        rst_n = 1'b0; #1;
        chk(lnk_word == usr_word && usr_ready, "R6", lnk_word, usr_word);
        chk(!ind_test, "R6", ind_test, 0);
        @(negedge clk); #1;
        chk(lnk_word == usr_word && !ind_test, "R6", lnk_word, usr_word);
        test_en = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        test_en = 1'b1; k = 0;
        run_words(wlen + 1, 0, "R6");
        release_at_boundary();

        finish_run();
    end
endmodule